// File: doc/BRIEF.md
# Lane-Selectable Operand Store

This block is the word-addressed storage that sits between a 32-bit host port and a wide modular arithmetic datapath. It keeps four working operands and one modulus. Each is up to 1536 bits wide and is held as 48 words of 32 bits, with word 0 the least significant. The host picks a location with a 9-bit address. The upper 3 bits name the operand and the lower 6 bits name the word inside it.

A 2-bit lane select sets which slice of each operand is live: the full width, the lower 16 words only, or the words from index 16 upward. Host accesses outside the live slice do nothing. A read of such a location returns zero, so a half-width operand always sits in its own half of the store. Reads have a fixed two-edge latency.

While the arithmetic core is running, it names the working operand it writes back into. A host write to that operand during the run raises a collision flag and is discarded.

Top module: `opstore_top`

## Requirements
- R1: Address bits [8:6] select the operand (0 to 3 for the working operands, 4 for the modulus) and bits [5:0] select the word. Selector values 5, 6 and 7 ignore writes and read as zero.
- R2: With lane select 2'b11, word indices 0 to 47 are written and read back. Indices 48 to 63 ignore writes and read as zero.
- R3: With lane select 2'b01, only word indices 0 to 15 are written and read back. All other indices ignore writes and read as zero.
- R4: With lane select 2'b10, only word indices 16 to 47 are written and read back. All other indices ignore writes and read as zero.
- R5: With lane select 2'b00, every write is ignored and every read returns zero.
- R6: Data for an address presented before clock edge N appears on the read output after edge N+1. After edge N alone, the output still shows the previous address's data.
- R7: The collision output is high in exactly the cycles where the host write enable is high, core_run is high and the address selector equals core_dest (0 to 3). The write in such a cycle is discarded. The modulus never collides.
- R8: A synchronous active-low reset clears every stored word and the read output to zero.
- R9: A write changes only the addressed word of the addressed operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write enable |
| host_addr | input | 9 | Operand selector [8:6] and word index [5:0] |
| host_wdata | input | 32 | Host write data |
| lane_sel | input | 2 | 00 off, 01 lower words, 10 upper words, 11 full width |
| core_run | input | 1 | High while the arithmetic core is computing |
| core_dest | input | 2 | Working operand the core writes its result into |
| host_rdata | output | 32 | Read data, two edges after the address |
| collision | output | 1 | Host write conflicts with the core's destination |

## Verification
On every cycle, the assertions check the following. The collision flag only appears with a host write during a run, and a flagged write never reaches storage. Reads of an invalid selector, an out-of-range index or the off lane return zero. The first output after reset is zero. Only the bench's scenarios can show that each live location keeps its own value, that half-width lanes keep to their half, and the exact two-edge read timing. To do this the bench writes a distinct pattern to all 512 addresses in each lane mode and reads every one back.

// File: rtl/opstore_pkg.sv
// Shared definitions for the operand store.
// Assumes the lane select is a 2-bit code as encoded below.
package opstore_pkg;

    typedef enum logic [1:0] {
        LANE_OFF  = 2'b00,
        LANE_LOW  = 2'b01,
        LANE_HIGH = 2'b10,
        LANE_FULL = 2'b11
    } lane_mode_e;

    // True when word index idx is live under the given lane mode.
    function automatic logic word_live(input lane_mode_e mode, input int unsigned idx,
                                       input int unsigned low_words, input int unsigned total_words);
        case (mode)
            LANE_FULL: return idx < total_words;
            LANE_LOW:  return idx < low_words;
            LANE_HIGH: return (idx >= low_words) && (idx < total_words);
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/opstore_lane_map.sv
// Decodes a host address into a one-hot operand hit and a word index.
// The hit is gated by the lane mode, so out-of-lane words never match.
// Assumes the selector occupies the top SEL_W bits of the address.
module opstore_lane_map
    import opstore_pkg::*;
#(
    parameter int SEL_W       = 3,
    parameter int IDX_W       = 6,
    parameter int N_OPS       = 5,
    parameter int LOW_WORDS   = 16,
    parameter int TOTAL_WORDS = 48
) (
    input  logic [SEL_W+IDX_W-1:0] addr,
    input  logic [1:0]             mode,
    output logic [N_OPS-1:0]       op_hit,
    output logic [IDX_W-1:0]       idx,
    output logic                   any_hit
);
    logic [SEL_W-1:0] sel;
    logic             live;

    // Split the address and qualify the index against the lane.
    always_comb begin
        sel  = addr[SEL_W+IDX_W-1:IDX_W];
        idx  = addr[IDX_W-1:0];
        live = word_live(lane_mode_e'(mode), int'(idx), LOW_WORDS, TOTAL_WORDS);
    end

    for (genvar g = 0; g < N_OPS; g++) begin : g_hit
        assign op_hit[g] = live && (sel == SEL_W'(g));
    end

    assign any_hit = |op_hit;
endmodule

// File: rtl/opstore_bank.sv
// Storage for one operand: DEPTH words with one write port and one
// combinational read port. Reset clears every word.
// Assumes the caller only raises we for indices below DEPTH.
module opstore_bank #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 48,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Hold the words; clear on reset, update the addressed word on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < DEPTH; i++)
                if (widx == IDX_W'(i)) mem[i] <= wdata;
        end
    end

    // Select the read word; indices past the end read as zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++)
            if (ridx == IDX_W'(i)) rdata = mem[i];
    end
endmodule

// File: rtl/opstore_top.sv
// Operand store: four working operands plus a modulus behind a 32-bit
// host port, with lane gating and core write-back collision detection.
// Reads take two edges: one to register the decoded address and one to
// register the selected word. Assumes core_dest names a working operand.
module opstore_top #(
    parameter int WORD_W      = 32,
    parameter int SEL_W       = 3,
    parameter int IDX_W       = 6,
    parameter int N_WORK      = 4,
    parameter int DEST_W      = 2,
    parameter int TOTAL_WORDS = 48,
    parameter int LOW_WORDS   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_we,
    input  logic [SEL_W+IDX_W-1:0] host_addr,
    input  logic [WORD_W-1:0]      host_wdata,
    input  logic [1:0]             lane_sel,
    input  logic                   core_run,
    input  logic [DEST_W-1:0]      core_dest,
    output logic [WORD_W-1:0]      host_rdata,
    output logic                   collision
);
    localparam int N_OPS = N_WORK + 1;

    logic [N_OPS-1:0]  op_hit;
    logic [IDX_W-1:0]  idx;
    logic              any_hit;
    logic              wr_commit;
    logic [N_OPS-1:0]  rd_op_q;
    logic [IDX_W-1:0]  rd_idx_q;
    logic              rd_hit_q;
    logic [WORD_W-1:0] bank_rd [N_OPS];
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] rdata_q;

    opstore_lane_map #(
        .SEL_W(SEL_W), .IDX_W(IDX_W), .N_OPS(N_OPS),
        .LOW_WORDS(LOW_WORDS), .TOTAL_WORDS(TOTAL_WORDS)
    ) u_map (
        .addr(host_addr), .mode(lane_sel),
        .op_hit(op_hit), .idx(idx), .any_hit(any_hit)
    );

    // Flag a host write aimed at the operand the running core writes back to.
    always_comb begin
        collision = host_we && core_run &&
                    (host_addr[SEL_W+IDX_W-1:IDX_W] == SEL_W'(core_dest));
        wr_commit = host_we && any_hit && !collision;
    end

    for (genvar g = 0; g < N_OPS; g++) begin : g_bank
        opstore_bank #(.WORD_W(WORD_W), .DEPTH(TOTAL_WORDS), .IDX_W(IDX_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .we(wr_commit && op_hit[g]), .widx(idx), .wdata(host_wdata),
            .ridx(rd_idx_q), .rdata(bank_rd[g])
        );
    end

    // First read stage: capture the decoded address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_op_q  <= '0;
            rd_idx_q <= '0;
            rd_hit_q <= 1'b0;
        end else begin
            rd_op_q  <= op_hit;
            rd_idx_q <= idx;
            rd_hit_q <= any_hit;
        end
    end

    // Merge the bank outputs under the registered one-hot operand select.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < N_OPS; i++)
            if (rd_op_q[i]) rd_mux = rd_mux | bank_rd[i];
    end

    // Second read stage: register the word for the host.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_hit_q ? rd_mux : '0;
    end

    assign host_rdata = rdata_q;
endmodule

// File: rtl/opstore_checker.sv
// Cycle-by-cycle properties of the operand store, bound to opstore_top.
// Uses a small age counter so two-cycle look-backs never reach before reset.
module opstore_checker #(
    parameter int WORD_W      = 32,
    parameter int SEL_W       = 3,
    parameter int IDX_W       = 6,
    parameter int N_WORK      = 4,
    parameter int TOTAL_WORDS = 48
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   host_we,
    input logic [SEL_W+IDX_W-1:0] host_addr,
    input logic [1:0]             lane_sel,
    input logic                   core_run,
    input logic                   collision,
    input logic [WORD_W-1:0]      host_rdata,
    input logic                   wr_commit
);
    logic [1:0] age;

    // Count cycles since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    a_r7_flag_needs_write_and_run: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> (host_we && core_run));

    a_r7_flagged_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> !wr_commit);

    a_r1_bad_selector_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && $past(host_addr[SEL_W+IDX_W-1:IDX_W] > SEL_W'(N_WORK), 2))
        |-> host_rdata == '0);

    a_r2_index_past_end_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && $past(host_addr[IDX_W-1:0] >= IDX_W'(TOTAL_WORDS), 2))
        |-> host_rdata == '0);

    a_r5_lane_off_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && $past(lane_sel == 2'b00, 2)) |-> host_rdata == '0);

    a_r8_output_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd0) |-> host_rdata == '0);
endmodule

bind opstore_top opstore_checker #(
    .WORD_W(WORD_W), .SEL_W(SEL_W), .IDX_W(IDX_W),
    .N_WORK(N_WORK), .TOTAL_WORDS(TOTAL_WORDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .lane_sel(lane_sel), .core_run(core_run), .collision(collision),
    .host_rdata(host_rdata), .wr_commit(wr_commit)
);

// File: tb/opstore_top_tb.sv
`timescale 1ns/1ps
module opstore_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [8:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [1:0]  lane_sel = 2'b11;
    logic        core_run = 1'b0;
    logic [1:0]  core_dest = 2'd0;
    logic [31:0] host_rdata;
    logic        collision;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    opstore_top u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .lane_sel(lane_sel), .core_run(core_run),
        .core_dest(core_dest), .host_rdata(host_rdata), .collision(collision)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; host_we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); host_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk); host_we = 1'b0; host_addr = a;
        @(posedge clk); @(posedge clk); @(negedge clk);
        d = host_rdata;
    endtask

    function automatic logic [31:0] pat(input logic [1:0] m, input logic [8:0] a);
        return {4'hA, 2'b00, m, 15'h0, a};
    endfunction

    function automatic bit live(input logic [1:0] m, input logic [8:0] a);
        int s = int'(a[8:6]);
        int i = int'(a[5:0]);
        if (s > 4) return 1'b0;
        case (m)
            2'b11: return i < 48;
            2'b01: return i < 16;
            2'b10: return i >= 16 && i < 48;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string mtag(input logic [1:0] m, input logic [8:0] a);
        if (a[8:6] > 3'd4) return "R1";
        case (m)
            2'b11: return "R2";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        logic [31:0] d;
        int coll_seen;
        do_reset();
        // R8: output and storage cleared by reset
        chk("R8 rdata after reset", host_rdata, 32'h0);
        rd({3'd0, 6'd0}, d);  chk("R8 op0 word0", d, 32'h0);
        rd({3'd4, 6'd47}, d); chk("R8 modulus word47", d, 32'h0);

        // Sweep every address in every lane mode
        for (int mi = 0; mi < 4; mi++) begin
            logic [1:0] m = 2'(mi);
            do_reset();
            lane_sel = m;
            coll_seen = 0;
            for (int a = 0; a < 512; a++) begin
                wr(9'(a), pat(m, 9'(a)));
                if (collision) coll_seen++;
            end
            chk("R7 no collision while idle", 32'(coll_seen), 32'h0);
            for (int a = 0; a < 512; a++) begin
                rd(9'(a), d);
                chk(mtag(m, 9'(a)), d, live(m, 9'(a)) ? pat(m, 9'(a)) : 32'h0);
            end
        end

        // R6: two-edge read latency
        do_reset();
        lane_sel = 2'b11;
        wr({3'd0, 6'd1}, 32'h1111_0001);
        wr({3'd3, 6'd2}, 32'h3333_0002);
        rd({3'd0, 6'd1}, d); chk("R6 first word", d, 32'h1111_0001);
        @(negedge clk); host_addr = {3'd3, 6'd2};
        @(posedge clk); @(negedge clk);
        chk("R6 one edge still old", host_rdata, 32'h1111_0001);
        @(posedge clk); @(negedge clk);
        chk("R6 two edges new", host_rdata, 32'h3333_0002);

        // R7: collision with the core's destination operand
        do_reset();
        lane_sel = 2'b11;
        core_run = 1'b1; core_dest = 2'd2;
        @(negedge clk); host_we = 1'b1; host_addr = {3'd2, 6'd5}; host_wdata = 32'hDEAD_0005;
        #1 chk("R7 collision raised", 32'(collision), 32'h1);
        @(negedge clk); host_we = 1'b0;
        #1 chk("R7 collision low without write", 32'(collision), 32'h0);
        rd({3'd2, 6'd5}, d); chk("R7 collided write dropped", d, 32'h0);
        @(negedge clk); host_we = 1'b1; host_addr = {3'd1, 6'd5}; host_wdata = 32'hBEEF_0105;
        #1 chk("R7 other operand no collision", 32'(collision), 32'h0);
        @(negedge clk); host_we = 1'b0;
        rd({3'd1, 6'd5}, d); chk("R7 other operand stored", d, 32'hBEEF_0105);
        @(negedge clk); host_we = 1'b1; host_addr = {3'd4, 6'd5}; host_wdata = 32'hCAFE_0405;
        #1 chk("R7 modulus no collision", 32'(collision), 32'h0);
        @(negedge clk); host_we = 1'b0;
        rd({3'd4, 6'd5}, d); chk("R7 modulus stored", d, 32'hCAFE_0405);
        // R9: neighbours untouched
        rd({3'd1, 6'd4}, d); chk("R9 neighbour word", d, 32'h0);
        rd({3'd0, 6'd5}, d); chk("R9 neighbour operand", d, 32'h0);
        core_run = 1'b0;
        @(negedge clk); host_we = 1'b1; host_addr = {3'd2, 6'd5}; host_wdata = 32'h5555_0205;
        #1 chk("R7 no collision after run", 32'(collision), 32'h0);
        @(negedge clk); host_we = 1'b0;
        rd({3'd2, 6'd5}, d); chk("R7 write after run stored", d, 32'h5555_0205);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule